// File: doc/BRIEF.md
# Four-Channel Edge-Selectable Input Capture Unit

This block watches four asynchronous input pins and, when a pin shows the edge its channel has been told to look for, stores the current value of a shared capture timer into that channel's capture register. The capture timer counts up once every (divider + 1) clocks while capture is switched on. Each capture also sets a per-channel status flag. A flag that is also enabled drives a single interrupt line.

Software drives the unit through a simple word-addressed register port with a one-cycle read latency. It sets an edge mode per channel, a clock divider and the run bit. It then waits for the interrupt, reads the status and capture registers, and writes ones to an acknowledge register to clear the flags it has handled. Only captures are handled here. Pulse generation belongs to other logic.

Top module: `icu_capture_top`

## Requirements
- R1: After a synchronous reset, the control, interrupt enable, status, edge mode and capture registers all read as zero, and `irq` is low.
- R2: An edge-detection pipeline made of a two-flop synchroniser and a history flop means that a pin change sampled at clock edge k is captured at edge k+2. The value stored is the timer value held just before edge k+2.
- R3: Each channel's edge mode sits at offset 0x30 + 4*ch. Only bits 1:0 are stored and the other bits read as zero. The encoding is 0 = never capture, 1 = rising edge, 2 = falling edge, 3 = either edge.
- R4: The control register sits at offset 0x50, with the divider in bits 8:4 and the run bit in bit 10. While run is 1, the timer steps by one every (divider + 1) clocks. While run is 0, the timer and divider count are held at zero and no edge is captured.
- R5: The capture register for a channel reads at offset 0x10 + 4*ch. A later qualifying edge overwrites it, even when that channel's status flag is still set.
- R6: The status register at 0x58 holds channel ch in bit ch+1. A flag is set only by a capture. Bit 0 and bits 5 and up read as zero.
- R7: Writing to the acknowledge register at 0x5C clears each status flag whose bit (ch+1) is 1 in the written word. Bit 0, bits 5 and up, and zero bits leave the flags unchanged.
- R8: The interrupt enable register at 0x54 uses the same bit layout as the status register. `irq` is registered and goes high on the clock after any flag is both set and enabled. Flags that are masked by the enable register never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears the next cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_in | input | 4 | Asynchronous capture pins, one per channel |
| irq | output | 1 | Interrupt: OR of enabled status flags |

## Verification
The bench drives each mode with edges of both polarities. An edge that does not match the mode must leave the status and capture registers untouched, and a decoder with the mode encodings swapped or a dropped polarity shows up as an unexpected interrupt or a missing one. Each expected capture value is computed from the cycle at which the pin changed, with both a divider of zero and a non-zero divider. An extra or missing pipeline stage, or an off-by-one in the divider, therefore shows up as a wrong captured count. The bench also checks that edges are ignored while run is off, that a second edge overwrites a pending capture, and that a masked flag keeps `irq` low. It checks that acknowledge bits aimed at other positions leave a flag set, which catches an acknowledge decoder shifted by one bit.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam logic [7:0] OFF_CAPT = 8'h10;
  localparam logic [7:0] OFF_MODE = 8'h30;
  localparam logic [7:0] OFF_CTRL = 8'h50;
  localparam logic [7:0] OFF_IEN  = 8'h54;
  localparam logic [7:0] OFF_ISTS = 8'h58;
  localparam logic [7:0] OFF_IACK = 8'h5C;

  localparam int CTRL_PSC_LSB = 4;
  localparam int CTRL_RUN_BIT = 10;
  localparam int IRQ_LSB      = 1;
  localparam int CH_STRIDE    = 4;

endpackage

// File: rtl/icu_timebase.sv
module icu_timebase #(
  parameter int PSC_W = 5,
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic [TMR_W-1:0] tmr
);

  logic [PSC_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      tmr   <= '0;
    end else if (div_q >= psc) begin
      div_q <= '0;
      tmr   <= tmr + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/icu_edge_detect.sv
module icu_edge_detect
  import icu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] mode,
  input  logic       pin,
  output logic       stb
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic            cur, prev, rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SH_W-2:0], pin};
  end

  assign cur  = sh_q[SYNC_STAGES-1];
  assign prev = sh_q[SYNC_STAGES];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    unique case (edge_mode_e'(mode))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign stb = run & hit;

endmodule

// File: rtl/icu_regfile.sv
module icu_regfile
  import icu_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int TMR_W  = 32,
  parameter int PSC_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_CH-1:0]   stb,
  input  logic [TMR_W-1:0]  tmr,
  output logic              run,
  output logic [PSC_W-1:0]  psc,
  output logic [2*N_CH-1:0] mode_flat,
  output logic [N_CH-1:0]   ists,
  output logic [N_CH-1:0]   ien,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic [1:0]       mode_q [N_CH];
  logic [TMR_W-1:0] capt_q [N_CH];
  logic [N_CH-1:0]  ack_bits;
  logic [DATA_W-1:0] rd_word;
  logic             wr_ctrl, wr_ien, wr_ack;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_ien   = bus_wr && (bus_addr == ADDR_W'(OFF_IEN));
  assign wr_ack   = bus_wr && (bus_addr == ADDR_W'(OFF_IACK));
  assign ack_bits = wr_ack ? bus_wdata[IRQ_LSB +: N_CH] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      psc <= '0;
    end else if (wr_ctrl) begin
      run <= bus_wdata[CTRL_RUN_BIT];
      psc <= bus_wdata[CTRL_PSC_LSB +: PSC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ien <= '0;
    else if (wr_ien) ien <= bus_wdata[IRQ_LSB +: N_CH];
  end

  always_ff @(posedge clk) begin
    if (rst) ists <= '0;
    else     ists <= stb | (ists & ~ack_bits);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_CH; i++) begin
      if (rst) begin
        mode_q[i] <= 2'b00;
      end else if (bus_wr &&
                   bus_addr == ADDR_W'(int'(OFF_MODE) + CH_STRIDE * i)) begin
        mode_q[i] <= bus_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_CH; i++) begin
      if (rst)         capt_q[i] <= '0;
      else if (stb[i]) capt_q[i] <= tmr;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_mode_out
    assign mode_flat[2*g +: 2] = mode_q[g];
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      rd_word[CTRL_PSC_LSB +: PSC_W] = psc;
      rd_word[CTRL_RUN_BIT]          = run;
    end
    if (bus_addr == ADDR_W'(OFF_IEN))  rd_word[IRQ_LSB +: N_CH] = ien;
    if (bus_addr == ADDR_W'(OFF_ISTS)) rd_word[IRQ_LSB +: N_CH] = ists;
    for (int i = 0; i < N_CH; i++) begin
      if (bus_addr == ADDR_W'(int'(OFF_CAPT) + CH_STRIDE * i))
        rd_word = DATA_W'(capt_q[i]);
      if (bus_addr == ADDR_W'(int'(OFF_MODE) + CH_STRIDE * i))
        rd_word = DATA_W'(mode_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(ists & ien);
  end

endmodule

// File: rtl/icu_capture_top.sv
module icu_capture_top #(
  parameter int N_CH        = 4,
  parameter int TMR_W       = 32,
  parameter int PSC_W       = 5,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_CH-1:0]   cap_in,
  output logic              irq
);

  logic              run_w;
  logic [PSC_W-1:0]  psc_w;
  logic [TMR_W-1:0]  tmr_w;
  logic [N_CH-1:0]   stb_w;
  logic [N_CH-1:0]   ists_w;
  logic [N_CH-1:0]   ien_w;
  logic [2*N_CH-1:0] mode_flat;

  icu_timebase #(.PSC_W(PSC_W), .TMR_W(TMR_W)) u_timebase (
    .clk (clk),
    .rst (rst),
    .run (run_w),
    .psc (psc_w),
    .tmr (tmr_w)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    icu_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .run  (run_w),
      .mode (mode_flat[2*g +: 2]),
      .pin  (cap_in[g]),
      .stb  (stb_w[g])
    );
  end

  icu_regfile #(
    .N_CH(N_CH), .TMR_W(TMR_W), .PSC_W(PSC_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stb       (stb_w),
    .tmr       (tmr_w),
    .run       (run_w),
    .psc       (psc_w),
    .mode_flat (mode_flat),
    .ists      (ists_w),
    .ien       (ien_w),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int N_CH  = 4,
  parameter int TMR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [N_CH-1:0]   stb,
  input logic [TMR_W-1:0]  tmr,
  input logic [N_CH-1:0]   ists,
  input logic [N_CH-1:0]   ien,
  input logic [2*N_CH-1:0] modes,
  input logic              irq
);

  // R4: timer is held at zero while capture is off
  p_timer_held_r4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (tmr == '0));

  // R4: timer never moves by more than one step per clock while running
  p_timer_step_r4: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (tmr == $past(tmr) || tmr == $past(tmr) + 1'b1));

  // R4: no capture strobe while capture is off
  p_no_capture_off_r4: assert property (@(posedge clk) disable iff (rst)
    !run |-> (stb == '0));

  // R8: enabled pending flag raises the line on the next clock
  p_irq_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (|(ists & ien)) |=> irq);

  // R8: no enabled flag means the line is low on the next clock
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !(|(ists & ien)) |=> !irq);

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    // R3: mode zero never captures
    p_mode_off_r3: assert property (@(posedge clk) disable iff (rst)
      (modes[2*g +: 2] == 2'b00) |-> !stb[g]);

    // R6: a capture leaves its flag set
    p_capture_sets_r6: assert property (@(posedge clk) disable iff (rst)
      stb[g] |=> ists[g]);

    // R6: a flag only rises after a capture strobe
    p_flag_source_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(ists[g]) |-> $past(stb[g]));
  end

endmodule

bind icu_capture_top icu_checker #(.N_CH(N_CH), .TMR_W(TMR_W)) u_icu_checker (
  .clk   (clk),
  .rst   (rst),
  .run   (run_w),
  .stb   (stb_w),
  .tmr   (tmr_w),
  .ists  (ists_w),
  .ien   (ien_w),
  .modes (mode_flat),
  .irq   (irq)
);

// File: tb/test_icu_capture_top.sv
module test_icu_capture_top;

  localparam int N_CH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N_CH-1:0] cap_in = '0;
  logic        irq;

  always #4 clk = ~clk;

  icu_capture_top i_icu_capture_top (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_in    (cap_in),
    .irq       (irq)
  );

  typedef struct {
    int          ch;
    logic [31:0] val;
  } item_t;

  item_t sb_q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int en_cyc = 0;
  int cur_psc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // R4: start the timer with a given divider, remembering the enable cycle
  task automatic start_timer(input int psc);
    bus_write(8'h50, 32'h0);
    bus_write(8'h50, (32'd1 << 10) | (32'(psc) << 4));
    en_cyc  = cyc;
    cur_psc = psc;
  endtask

  // R2/R4: value expected for a pin change driven when cyc == cd
  function automatic logic [31:0] exp_val(input int cd);
    return 32'((cd + 2 - en_cyc) / (cur_psc + 1));
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pin(input int ch, input logic v, output int cd);
    @(negedge clk);
    cd = cyc;
    cap_in[ch] = v;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sb_q.size() == 0 && !irq) break;
    end
    check("R8 interrupt serviced for expected capture", 32'(sb_q.size()), 32'd0);
  endtask

  // driver: push the expected capture, then make the edge
  task automatic expect_edge(input int ch, input logic v);
    item_t it;
    @(negedge clk);
    it.ch  = ch;
    it.val = exp_val(cyc);
    sb_q.push_back(it);
    cap_in[ch] = v;
    wait_drain();
  endtask

  // monitor: on each interrupt, compare status and capture with the queue head
  initial begin
    logic [31:0] d;
    forever begin
      @(posedge irq);
      if (sb_q.size() == 0) begin
        n_chk++; n_err++;
        bus_read(8'h58, d);
        $display("FAIL R3 unexpected interrupt actual status=%h expected none", d);
        bus_write(8'h5C, 32'h1FF);
      end else begin
        bus_read(8'h58, d);
        check("R6 status bit for captured channel", d, 32'd1 << (sb_q[0].ch + 1));
        bus_read(8'(8'h10 + 4 * sb_q[0].ch), d);
        check("R2 captured timer value", d, sb_q[0].val);
        bus_write(8'h5C, 32'd1 << (sb_q[0].ch + 1));
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cd;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    check("R1 irq after reset", 32'(irq), 32'd0);
    bus_read(8'h50, d); check("R1 control reset", d, 32'd0);
    bus_read(8'h54, d); check("R1 enable reset", d, 32'd0);
    bus_read(8'h58, d); check("R1 status reset", d, 32'd0);
    bus_read(8'h10, d); check("R1 capture reset", d, 32'd0);
    bus_read(8'h3C, d); check("R1 mode reset", d, 32'd0);

    // R3: modes, only bits 1:0 kept
    bus_write(8'h30, 32'hFFFF_FFFD);
    bus_read(8'h30, d); check("R3 mode keeps bits 1:0 only", d, 32'd1);
    bus_write(8'h34, 32'd2);
    bus_write(8'h38, 32'd3);
    bus_write(8'h3C, 32'd0);
    bus_write(8'h54, 32'h1E);
    start_timer(0);
    bus_read(8'h50, d); check("R4 control readback", d, 32'h400);

    // R2 R5: rising capture on channel 0
    idle(7);
    expect_edge(0, 1'b1);
    drive_pin(0, 1'b0, cd); idle(6);
    bus_read(8'h58, d); check("R3 falling edge ignored in rising mode", d, 32'd0);

    // R3: falling mode on channel 1
    drive_pin(1, 1'b1, cd); idle(6);
    bus_read(8'h58, d); check("R3 rising edge ignored in falling mode", d, 32'd0);
    idle(3);
    expect_edge(1, 1'b0);

    // R3: either-edge mode on channel 2
    idle(5);
    expect_edge(2, 1'b1);
    idle(9);
    expect_edge(2, 1'b0);

    // R3: off mode on channel 3
    drive_pin(3, 1'b1, cd); idle(4);
    drive_pin(3, 1'b0, cd); idle(6);
    bus_read(8'h58, d); check("R3 mode zero never sets status", d, 32'd0);
    bus_read(8'h1C, d); check("R3 mode zero leaves capture", d, 32'd0);

    // R4: divider of 3
    start_timer(3);
    idle(23);
    expect_edge(0, 1'b1);
    idle(2);
    expect_edge(2, 1'b1);

    // R4: edges ignored while capture is off
    bus_write(8'h50, 32'h0);
    drive_pin(0, 1'b0, cd); idle(4);
    drive_pin(0, 1'b1, cd); idle(6);
    bus_read(8'h58, d); check("R4 no capture while off", d, 32'd0);

    // R5 R8: overwrite while pending, masked interrupt
    bus_write(8'h54, 32'h0);
    start_timer(0);
    drive_pin(0, 1'b0, cd); idle(6);
    drive_pin(0, 1'b1, cd); idle(6);
    bus_read(8'h58, d); check("R6 flag set by capture", d, 32'h2);
    check("R8 masked flag keeps irq low", 32'(irq), 32'd0);
    drive_pin(0, 1'b0, cd); idle(6);
    drive_pin(0, 1'b1, cd); idle(6);
    bus_read(8'h10, d); check("R5 second edge overwrites capture", d, exp_val(cd));
    bus_read(8'h58, d); check("R5 flag still set after overwrite", d, 32'h2);
    begin
      item_t it;
      it.ch = 0; it.val = exp_val(cd);
      sb_q.push_back(it);
    end
    bus_write(8'h54, 32'h2);
    wait_drain();

    // R7: acknowledge bits aimed elsewhere leave the flag
    bus_write(8'h54, 32'h0);
    drive_pin(2, 1'b0, cd); idle(6);
    bus_read(8'h58, d); check("R6 either-edge flag set", d, 32'h8);
    bus_write(8'h5C, 32'hFFFF_FFF7);
    bus_read(8'h58, d); check("R7 other ack bits ignored", d, 32'h8);
    bus_write(8'h5C, 32'h8);
    bus_read(8'h58, d); check("R7 ack clears its flag", d, 32'h0);
    check("R8 irq low at end", 32'(irq), 32'd0);

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule